// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block holds the software-visible registers of a single DMA channel that sits on a 32-bit, word-access register bus. It keeps the channel status word, the descriptor pointer and three condition-select registers (interrupt, branch and wait). A write to the control address does not store anything by itself. It is a masked update: the upper half selects the bits that change and the lower half gives their new values. The block applies these updates to the run, pause, wake and flush bits of the status word.

From the resulting status the block works out the channel's active bit. When the channel stops or software asks for a flush, it requests a flush from the device. After a control write that leaves the channel active, it sends the descriptor sequencer a one-cycle start pulse. The sequencer reports back through three strobes: a descriptor fetch, a stop and a fatal error. The device reports that a flush has finished through a done strobe. Reading the control address returns the status word, so software reads back what it has just updated.

Top module: `dma_chan_regs`

## Requirements
- R1: A write to the control address (word index 0) changes only those status bits whose mask bit is set in wdata[31:16]. The new value comes from the same bit position in wdata[15:0]. A write with an all-zero mask leaves the status unchanged.
- R2: A masked control write with run (bit 15) set to one sets run. A masked write with run set to zero clears both run and dead (bit 11).
- R3: A masked wake (bit 12) written as one sets wake only if run is set after the same write. A seq_fetch_i strobe clears wake.
- R4: A masked pause (bit 14) write copies the value bit into status.
- R5: After a control write, if pause is set or run is clear, active (bit 10) is cleared and flush_req_o pulses in the next cycle. Otherwise active is set when run or pause was in the mask, or when wake was written as one. start_o pulses in the cycle after any control write that leaves active set.
- R6: A masked flush (bit 13) written as one sets flush in status and pulses flush_req_o. Flush stays set until flush_done_i is seen, then clears.
- R7: A write to the descriptor pointer (word index 5) is ignored while active is set. Bits 3:0 of the stored pointer always read as zero.
- R8: Reads return data one cycle after the request, with rvalid_o high. Word indices 0 and 1 both return the status word. Indices 2, 3 and 4 return the interrupt, branch and wait select registers. Index 5 returns the pointer. Indices 6 and 7 read as zero.
- R9: Reset (rst_ni low) clears the status, the pointer and all select registers to zero.
- R10: Only accesses with size_i equal to 4 bytes take effect. A write of any other size is ignored, and a read of any other size gives no rvalid_o.
- R11: seq_stop_i clears active. seq_kill_i sets dead and clears active.
- R12: A write to the status address (index 1) changes only the device condition bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register word index |
| size_i | input | 3 | Access size in bytes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid |
| flush_done_i | input | 1 | Device has finished a flush |
| seq_fetch_i | input | 1 | Sequencer fetched a descriptor |
| seq_stop_i | input | 1 | Sequencer halted on a stop descriptor |
| seq_kill_i | input | 1 | Sequencer hit a fatal error |
| flush_req_o | output | 1 | Pulse asking the device to flush |
| start_o | output | 1 | Pulse telling the sequencer to run |
| status_o | output | 32 | Current status word |
| cmd_ptr_o | output | 32 | Descriptor pointer |
| intr_sel_o | output | 32 | Interrupt condition select |
| br_sel_o | output | 32 | Branch condition select |
| wait_sel_o | output | 32 | Wait condition select |

## Verification
The bench checks several corner cases of the active precedence rule:
- A write that sets pause while running must drop active and request a flush. A design that only copies the bits would leave the channel active.
- A wake written with run clear must set neither wake nor active. A design that does not gate wake on run would start a stopped channel.
- Clearing run after a fatal error must also clear dead. A design that misses this would report dead forever.

It also checks the narrower rules:
- A pointer write while active must be dropped. A design that accepts it would redirect a running channel.
- The flush bit must stay visible across idle cycles and drop only on the done strobe.
- Writes with a size other than 4 bytes, and status writes touching bits above 3:0, must leave everything else as it was.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int REG_AW  = 3;
  localparam int B_RUN   = 15;
  localparam int B_PAUSE = 14;
  localparam int B_FLUSH = 13;
  localparam int B_WAKE  = 12;
  localparam int B_DEAD  = 11;
  localparam int B_ACT   = 10;
  localparam int DEV_W   = 4;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL = 3'd0,
    A_STAT = 3'd1,
    A_ISEL = 3'd2,
    A_BSEL = 3'd3,
    A_WSEL = 3'd4,
    A_CPTR = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/chan_bus_dec.sv
module chan_bus_dec
  import dma_chan_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 3,
  parameter int SZW  = 3,
  parameter int NSEL = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [SZW-1:0] size_i,
  input  logic [DW-1:0]  status_i,
  input  logic [DW-1:0]  cptr_i,
  input  logic [DW-1:0]  sel_i [NSEL],
  output logic           ctrl_we_o,
  output logic           stat_we_o,
  output logic           cptr_we_o,
  output logic [NSEL-1:0] sel_we_o,
  output logic [DW-1:0]  rdata_o,
  output logic           rvalid_o
);
  localparam int ACC_BYTES = DW / 8;
  localparam int SEL_BASE  = int'(A_ISEL);

  logic acc_ok, wr, rd;
  logic [DW-1:0] rd_mux;

  assign acc_ok    = req_i && (size_i == SZW'(ACC_BYTES));
  assign wr        = acc_ok && we_i;
  assign rd        = acc_ok && !we_i;
  assign ctrl_we_o = wr && (addr_i == AW'(A_CTRL));
  assign stat_we_o = wr && (addr_i == AW'(A_STAT));
  assign cptr_we_o = wr && (addr_i == AW'(A_CPTR));

  for (genvar g = 0; g < NSEL; g++) begin : g_sel_we
    assign sel_we_o[g] = wr && (addr_i == AW'(SEL_BASE + g));
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == AW'(A_CTRL) || addr_i == AW'(A_STAT)) rd_mux = status_i;
    else if (addr_i == AW'(A_CPTR)) rd_mux = cptr_i;
    for (int k = 0; k < NSEL; k++) begin
      if (addr_i == AW'(SEL_BASE + k)) rd_mux = sel_i[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/chan_ctl_stat.sv
module chan_ctl_stat
  import dma_chan_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic          stat_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          flush_done_i,
  input  logic          seq_fetch_i,
  input  logic          seq_stop_i,
  input  logic          seq_kill_i,
  output logic [DW-1:0] status_o,
  output logic          flush_req_o,
  output logic          start_o
);
  localparam int HW = DW / 2;

  logic [DW-1:0] status_q, st;
  logic [HW-1:0] msk, val;
  logic do_flush, kick, wake_wr;

  assign msk = wdata_i[DW-1:HW];
  assign val = wdata_i[HW-1:0];
  assign wake_wr = msk[B_WAKE] && val[B_WAKE];

  always_comb begin
    st       = status_q;
    do_flush = 1'b0;
    kick     = 1'b0;
    // hardware events first, a same-cycle control write lands on top
    if (flush_done_i) st[B_FLUSH] = 1'b0;
    if (seq_fetch_i)  st[B_WAKE]  = 1'b0;
    if (seq_stop_i)   st[B_ACT]   = 1'b0;
    if (seq_kill_i) begin
      st[B_DEAD] = 1'b1;
      st[B_ACT]  = 1'b0;
    end
    if (ctrl_we_i) begin
      if (msk[B_RUN]) begin
        st[B_RUN] = val[B_RUN];
        if (!val[B_RUN]) st[B_DEAD] = 1'b0;
      end
      if (wake_wr && st[B_RUN]) st[B_WAKE] = 1'b1;
      if (msk[B_PAUSE]) st[B_PAUSE] = val[B_PAUSE];
      if (msk[B_FLUSH] && val[B_FLUSH]) begin
        st[B_FLUSH] = 1'b1;
        do_flush    = 1'b1;
      end
      if (st[B_PAUSE] || !st[B_RUN]) begin
        st[B_ACT] = 1'b0;
        do_flush  = 1'b1;
      end else if (msk[B_RUN] || msk[B_PAUSE] || wake_wr) begin
        st[B_ACT] = 1'b1;
      end
      kick = st[B_ACT];
    end
    if (stat_we_i) st[DEV_W-1:0] = wdata_i[DEV_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q    <= '0;
      flush_req_o <= 1'b0;
      start_o     <= 1'b0;
    end else begin
      status_q    <= st;
      flush_req_o <= do_flush;
      start_o     <= kick;
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/chan_cfg_regs.sv
module chan_cfg_regs #(
  parameter int DW      = 32,
  parameter int NSEL    = 3,
  parameter int PTR_LSB = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DW-1:0]   wdata_i,
  input  logic            cptr_we_i,
  input  logic [NSEL-1:0] sel_we_i,
  input  logic            active_i,
  output logic [DW-1:0]   cptr_o,
  output logic [DW-1:0]   sel_o [NSEL]
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cptr_o <= '0;
    else if (cptr_we_i && !active_i)
      cptr_o <= {wdata_i[DW-1:PTR_LSB], {PTR_LSB{1'b0}}};
  end

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sel_o[g] <= '0;
      else if (sel_we_i[g]) sel_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int DW      = 32,
  parameter int AW      = 3,
  parameter int SZW     = 3,
  parameter int PTR_LSB = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [SZW-1:0] size_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic           rvalid_o,
  input  logic           flush_done_i,
  input  logic           seq_fetch_i,
  input  logic           seq_stop_i,
  input  logic           seq_kill_i,
  output logic           flush_req_o,
  output logic           start_o,
  output logic [DW-1:0]  status_o,
  output logic [DW-1:0]  cmd_ptr_o,
  output logic [DW-1:0]  intr_sel_o,
  output logic [DW-1:0]  br_sel_o,
  output logic [DW-1:0]  wait_sel_o
);
  localparam int NSEL = 3;

  logic ctrl_we, stat_we, cptr_we;
  logic [NSEL-1:0] sel_we;
  logic [DW-1:0] sel [NSEL];

  chan_bus_dec #(.DW(DW), .AW(AW), .SZW(SZW), .NSEL(NSEL)) i_dec (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .size_i,
    .status_i (status_o),
    .cptr_i   (cmd_ptr_o),
    .sel_i    (sel),
    .ctrl_we_o(ctrl_we),
    .stat_we_o(stat_we),
    .cptr_we_o(cptr_we),
    .sel_we_o (sel_we),
    .rdata_o, .rvalid_o
  );

  chan_ctl_stat #(.DW(DW)) i_ctl (
    .clk_i, .rst_ni,
    .ctrl_we_i(ctrl_we),
    .stat_we_i(stat_we),
    .wdata_i,
    .flush_done_i, .seq_fetch_i, .seq_stop_i, .seq_kill_i,
    .status_o, .flush_req_o, .start_o
  );

  chan_cfg_regs #(.DW(DW), .NSEL(NSEL), .PTR_LSB(PTR_LSB)) i_cfg (
    .clk_i, .rst_ni, .wdata_i,
    .cptr_we_i(cptr_we),
    .sel_we_i (sel_we),
    .active_i (status_o[B_ACT]),
    .cptr_o   (cmd_ptr_o),
    .sel_o    (sel)
  );

  assign intr_sel_o = sel[0];
  assign br_sel_o   = sel[1];
  assign wait_sel_o = sel[2];
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
  import dma_chan_pkg::*;
#(
  parameter int DW  = 32,
  parameter int AW  = 3,
  parameter int SZW = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_i,
  input logic           we_i,
  input logic [AW-1:0]  addr_i,
  input logic [SZW-1:0] size_i,
  input logic           rvalid_o,
  input logic           flush_done_i,
  input logic           flush_req_o,
  input logic           start_o,
  input logic [DW-1:0]  status_o,
  input logic [DW-1:0]  cmd_ptr_o
);
  // R5
  active_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[B_ACT] |-> (status_o[B_RUN] && !status_o[B_PAUSE]));
  // R5
  start_when_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> status_o[B_ACT]);
  // R6
  flush_req_after_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o |-> $past(req_i && we_i && addr_i == AW'(A_CTRL) && size_i == SZW'(DW/8)));
  // R6
  flush_clear_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[B_FLUSH]) |-> $past(flush_done_i));
  // R7
  ptr_hold_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(status_o[B_ACT]) |-> $stable(cmd_ptr_o));
  // R2
  dead_clear_with_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[B_DEAD]) |-> !status_o[B_RUN]);
  // R10
  read_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i && size_i == SZW'(DW/8)));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.DW(DW), .AW(AW), .SZW(SZW)) i_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .size_i, .rvalid_o,
  .flush_done_i, .flush_req_o, .start_o, .status_o, .cmd_ptr_o
);

// File: tb/test_dma_chan_regs.sv
`timescale 1ns/1ps
module test_dma_chan_regs;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 0, we = 0, fdone = 0, sfetch = 0, sstop = 0, skill = 0;
  logic [2:0] addr = '0, size = 3'd4;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, status, cptr, isel, bsel, wsel;
  logic rvalid, freq, start;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  dma_chan_regs i_dma_chan_regs (
    .clk_i(clk), .rst_ni, .req_i(req), .we_i(we), .addr_i(addr), .size_i(size),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .flush_done_i(fdone), .seq_fetch_i(sfetch), .seq_stop_i(sstop), .seq_kill_i(skill),
    .flush_req_o(freq), .start_o(start), .status_o(status), .cmd_ptr_o(cptr),
    .intr_sel_o(isel), .br_sel_o(bsel), .wait_sel_o(wsel)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R8: actual %h expected no read", rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d, logic [2:0] sz = 3'd4);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d; size = sz;
    @(negedge clk); req = 0; we = 0; size = 3'd4;
  endtask

  task automatic rd(string tag, logic [2:0] a, logic [31:0] e);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0;
    @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    chk("R9 status after reset", status, 32'h0);
    rd("R9 read ctrl", 3'd0, 32'h0);
    rd("R9 read ptr", 3'd5, 32'h0);
    rd("R9 read isel", 3'd2, 32'h0);

    wr(3'd0, 32'h8000_8000);
    chk("R2 run set", status, 32'h0000_8400);
    chk("R5 start pulse", {31'b0, start}, 32'h1);
    chk("R5 no flush when running", {31'b0, freq}, 32'h0);
    @(negedge clk);
    chk("R5 start single cycle", {31'b0, start}, 32'h0);

    wr(3'd5, 32'h1234_5678);
    rd("R7 ptr ignored while active", 3'd5, 32'h0);

    wr(3'd0, 32'h4000_4000);
    chk("R4 pause copied", status, 32'h0000_C000);
    chk("R5 stop requests flush", {31'b0, freq}, 32'h1);
    wr(3'd0, 32'h4000_0000);
    chk("R5 unpause reactivates", status, 32'h0000_8400);

    pulse(sstop);
    chk("R11 seq stop clears active", status, 32'h0000_8000);
    wr(3'd5, 32'hABCD_EF17);
    rd("R7 ptr aligned write", 3'd5, 32'hABCD_EF10);

    wr(3'd0, 32'h1000_1000);
    chk("R3 wake with run", status, 32'h0000_9400);
    pulse(sfetch);
    chk("R3 fetch clears wake", status, 32'h0000_8400);

    pulse(skill);
    chk("R11 kill sets dead", status, 32'h0000_8800);
    wr(3'd0, 32'h8000_0000);
    chk("R2 run clear clears dead", status, 32'h0);
    chk("R5 run clear requests flush", {31'b0, freq}, 32'h1);

    wr(3'd0, 32'h1000_1000);
    chk("R3 wake ignored without run", status, 32'h0);

    wr(3'd0, 32'h8000_8000);
    wr(3'd0, 32'h2000_2000);
    chk("R6 flush visible", status, 32'h0000_A400);
    chk("R6 flush request", {31'b0, freq}, 32'h1);
    rd("R6 flush read back", 3'd0, 32'h0000_A400);
    repeat (3) @(negedge clk);
    chk("R6 flush held until done", status, 32'h0000_A400);
    pulse(fdone);
    chk("R6 flush cleared by done", status, 32'h0000_8400);

    wr(3'd0, 32'h0000_FFFF);
    chk("R1 empty mask no change", status, 32'h0000_8400);

    wr(3'd0, 32'h8000_0000, 3'd2);
    chk("R10 short write ignored", status, 32'h0000_8400);
    @(negedge clk); req = 1; we = 0; addr = 3'd0; size = 3'd2;
    @(negedge clk); req = 0; size = 3'd4;
    chk("R10 short read no valid", {31'b0, rvalid}, 32'h0);

    wr(3'd2, 32'h000F_0005);
    wr(3'd3, 32'h0003_0001);
    wr(3'd4, 32'h000C_0008);
    rd("R8 isel", 3'd2, 32'h000F_0005);
    rd("R8 bsel", 3'd3, 32'h0003_0001);
    rd("R8 wsel", 3'd4, 32'h000C_0008);
    rd("R8 status index", 3'd1, 32'h0000_8400);
    rd("R8 unused index", 3'd6, 32'h0);

    wr(3'd1, 32'hFFFF_FFFF);
    chk("R12 status write dev bits only", status, 32'h0000_840F);
    rd("R8 ctrl returns status", 3'd0, 32'h0000_840F);

    @(negedge clk); rst_ni = 0;
    @(negedge clk); rst_ni = 1;
    chk("R9 status cleared", status, 32'h0);
    chk("R9 ptr cleared", cptr, 32'h0);
    rd("R9 wsel cleared", 3'd4, 32'h0);

    repeat (2) @(negedge clk);
    chk("R8 all reads returned", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule